// File: doc/BRIEF.md
# DRAM Controller Boot Register Model

This block stands in for the configuration and status registers of a DRAM controller during boot. It keeps no data and models no DRAM timing. A boot routine reaches it through a simple one-cycle register bus with four window selects. Three of the windows are register windows: common, controller and PHY, each 4 KiB of 32-bit words. The fourth window stands for the address range of a second rank. A boot routine probes that range to learn whether the rank is fitted.

The block gives the bring-up handshake. Writing the PHY init register raises an init-done flag and an active flag in two status registers, and the routine polls for those flags. When software writes the common control word in single-rank mode, the block decodes the row, bank and column widths from it. It drives these widths to a companion block with a one-cycle update strobe. A read in the second-rank window always returns zero. When a timeout-enable bit is set, the same read also raises a sticky timeout flag, so the probe finds that the rank is missing.

Top module: `dram_boot_regs`

## Requirements
- R1: `reqReady` is always high. Each access with `reqValid` high completes in that cycle. `rspValid` is high exactly one cycle later, with `rspRdata` holding the read word. `rspRdata` is zero for writes. The word index is `reqAddr[11:2]`, and at most one window select is high.
- R2: A write to common index 0 with bit 0 clear loads the geometry outputs on the next cycle: rows = bits[7:4]+1, banks = bit 2 + 2, columns = bits[11:8]+3. `geoUpdate` is high for exactly that one cycle.
- R3: A write to common index 0 stores the full 32-bit word, whatever bit 0 holds, and a read returns the stored word.
- R4: A write to common index 0 with bit 0 set (dual-rank) leaves the geometry outputs unchanged and gives no `geoUpdate` pulse.
- R5: A write to controller index 0 (byte 0x000) stores the written word there. It also sets bit 0 of PHY status (byte 0x010) and bit 0 of run status (byte 0x018).
- R6: A read in the probe window returns zero. If bit 25 of PHY config (controller byte 0x100) is set, the read also sets bit 13 of PHY status. Writes to the probe window change nothing.
- R7: A status bit set by the block stays set until software writes the register that holds it. A direct write replaces the whole word.
- R8: Reset clears every register in all three windows and the geometry outputs to zero.
- R9: A read at an index at or above a window's register count returns zero. A write there is dropped and does not alias onto a lower register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request |
| reqReady | output | 1 | Always high: each access takes one cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSelCom | input | 1 | Selects the common window |
| reqSelCtl | input | 1 | Selects the controller window |
| reqSelPhy | input | 1 | Selects the PHY window |
| reqSelProbe | input | 1 | Selects the second-rank probe window |
| reqAddr | input | 12 | Byte offset within the window |
| reqWdata | input | 32 | Write word |
| rspValid | output | 1 | Response one cycle after an access |
| rspRdata | output | 32 | Read word, zero for writes |
| geoRowBits | output | 5 | Decoded row address width |
| geoBankBits | output | 2 | Decoded bank address width |
| geoColBits | output | 5 | Decoded column address width |
| geoUpdate | output | 1 | One-cycle strobe when the geometry is loaded |

## Verification
The bench sets the common window to 2 registers and the PHY window to 8. It keeps the controller window at 72 registers, which is enough to reach the config word at index 64. The small windows put out-of-range indices right above the last real register. A write at PHY index 8 or common index 2 would land on index 0 if the index were cut to the array width. The bench therefore watches index 0 after those writes to catch such aliasing.

// File: rtl/dram_boot_pkg.sv
package dram_boot_pkg;

  localparam int WIN_ADDR_W = 12;
  localparam int WORD_IDX_W = WIN_ADDR_W - 2;
  localparam int DATA_W     = 32;

  // controller-window word indices the handshake depends on
  localparam int IDX_INIT  = 0;   // byte 0x000
  localparam int IDX_PSTAT = 4;   // byte 0x010
  localparam int IDX_RSTAT = 6;   // byte 0x018
  localparam int IDX_PCFG  = 64;  // byte 0x100

  localparam int BIT_INIT_DONE = 0;
  localparam int BIT_ACTIVE    = 0;
  localparam int BIT_RD_TMO    = 13;
  localparam int BIT_TMO_EN    = 25;
  localparam int BIT_DUAL      = 0;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_COM,
    WIN_CTL,
    WIN_PHY,
    WIN_PROBE
  } win_e;

  typedef struct packed {
    win_e                  win;
    logic [WORD_IDX_W-1:0] idx;
    logic                  inRange;
    logic                  wrEn;
    logic                  rdReq;
    logic                  geoLoad;
    logic                  initHit;
    logic                  probeRd;
  } strobe_t;

endpackage

// File: rtl/dram_boot_ctrl.sv
module dram_boot_ctrl
  import dram_boot_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_CTL = 72,
  parameter int NUM_PHY = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqSelCom,
  input  logic                  reqSelCtl,
  input  logic                  reqSelPhy,
  input  logic                  reqSelProbe,
  input  logic [WIN_ADDR_W-1:0] reqAddr,
  input  logic                  wBitDual,
  output strobe_t               stb,
  output logic                  rspValid
);

  localparam logic [WORD_IDX_W-1:0] COM_LIM = WORD_IDX_W'(NUM_COM);
  localparam logic [WORD_IDX_W-1:0] CTL_LIM = WORD_IDX_W'(NUM_CTL);
  localparam logic [WORD_IDX_W-1:0] PHY_LIM = WORD_IDX_W'(NUM_PHY);

  win_e                  win;
  logic [WORD_IDX_W-1:0] idx;
  logic                  inRange;

  assign idx = reqAddr[WIN_ADDR_W-1:2];

  always_comb begin
    if (reqSelCom)        win = WIN_COM;
    else if (reqSelCtl)   win = WIN_CTL;
    else if (reqSelPhy)   win = WIN_PHY;
    else if (reqSelProbe) win = WIN_PROBE;
    else                  win = WIN_NONE;
  end

  always_comb begin
    unique case (win)
      WIN_COM: inRange = idx < COM_LIM;
      WIN_CTL: inRange = idx < CTL_LIM;
      WIN_PHY: inRange = idx < PHY_LIM;
      default: inRange = 1'b0;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.win     = win;
    stb.idx     = idx;
    stb.inRange = inRange;
    stb.wrEn    = reqValid && reqWrite && inRange;
    stb.rdReq   = reqValid && !reqWrite &&
                  (win == WIN_COM || win == WIN_CTL || win == WIN_PHY);
    stb.geoLoad = reqValid && reqWrite && win == WIN_COM &&
                  idx == '0 && !wBitDual;
    stb.initHit = reqValid && reqWrite && win == WIN_CTL &&
                  idx == WORD_IDX_W'(IDX_INIT);
    stb.probeRd = reqValid && !reqWrite && win == WIN_PROBE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R1: at most one window per access
  a_r1_one_window: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0({reqSelCom, reqSelCtl, reqSelPhy, reqSelProbe}));

  // R1: word accesses only
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[1:0] == 2'b00);

  // R1: response follows each access by one cycle
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/dram_boot_bank.sv
module dram_boot_bank
  import dram_boot_pkg::*;
#(
  parameter int NUM = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [WORD_IDX_W-1:0] idx,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdWord
);

  logic [DATA_W-1:0] regs [NUM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (wrEn && idx == WORD_IDX_W'(i)) regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == WORD_IDX_W'(i)) rdWord = regs[i];
    end
  end

endmodule

// File: rtl/dram_boot_datapath.sv
module dram_boot_datapath
  import dram_boot_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_CTL = 72,
  parameter int NUM_PHY = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [4:0]        geoRowBits,
  output logic [1:0]        geoBankBits,
  output logic [4:0]        geoColBits,
  output logic              geoUpdate
);

  logic              comWr, phyWr, ctlWr;
  logic [DATA_W-1:0] comRd, phyRd, ctlRd;
  logic [DATA_W-1:0] ctlRegs [NUM_CTL];

  assign comWr = stb.wrEn && stb.win == WIN_COM;
  assign ctlWr = stb.wrEn && stb.win == WIN_CTL;
  assign phyWr = stb.wrEn && stb.win == WIN_PHY;

  dram_boot_bank #(.NUM(NUM_COM)) u_com (
    .clk(clk), .rstN(rstN), .wrEn(comWr), .idx(stb.idx),
    .wdata(wdata), .rdWord(comRd));

  dram_boot_bank #(.NUM(NUM_PHY)) u_phy (
    .clk(clk), .rstN(rstN), .wrEn(phyWr), .idx(stb.idx),
    .wdata(wdata), .rdWord(phyRd));

  // controller window: plain storage plus hardware-set status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CTL; i++) ctlRegs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CTL; i++) begin
        if (ctlWr && stb.idx == WORD_IDX_W'(i)) ctlRegs[i] <= wdata;
      end
      if (stb.initHit) begin
        ctlRegs[IDX_PSTAT][BIT_INIT_DONE] <= 1'b1;
        ctlRegs[IDX_RSTAT][BIT_ACTIVE]    <= 1'b1;
      end
      if (stb.probeRd && ctlRegs[IDX_PCFG][BIT_TMO_EN])
        ctlRegs[IDX_PSTAT][BIT_RD_TMO] <= 1'b1;
    end
  end

  always_comb begin
    ctlRd = '0;
    for (int i = 0; i < NUM_CTL; i++) begin
      if (stb.idx == WORD_IDX_W'(i)) ctlRd = ctlRegs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else begin
      rspRdata <= '0;
      if (stb.rdReq && stb.inRange) begin
        unique case (stb.win)
          WIN_COM: rspRdata <= comRd;
          WIN_CTL: rspRdata <= ctlRd;
          WIN_PHY: rspRdata <= phyRd;
          default: rspRdata <= '0;
        endcase
      end
    end
  end

  // geometry decode from the common control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      geoRowBits  <= '0;
      geoBankBits <= '0;
      geoColBits  <= '0;
      geoUpdate   <= 1'b0;
    end else begin
      geoUpdate <= stb.geoLoad;
      if (stb.geoLoad) begin
        geoRowBits  <= {1'b0, wdata[7:4]} + 5'd1;
        geoBankBits <= {1'b0, wdata[2]} + 2'd2;
        geoColBits  <= {1'b0, wdata[11:8]} + 5'd3;
      end
    end
  end

  // R2: strobe follows a single-rank control write
  a_r2_geo_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stb.geoLoad |=> geoUpdate);

  // R4: no load, no change
  a_r4_geo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.geoLoad |=> !geoUpdate && $stable(geoRowBits) &&
                     $stable(geoBankBits) && $stable(geoColBits));

  // R5: init command raises both completion flags
  a_r5_init_flags: assert property (@(posedge clk) disable iff (!rstN)
    stb.initHit |=> ctlRegs[IDX_PSTAT][BIT_INIT_DONE] &&
                    ctlRegs[IDX_RSTAT][BIT_ACTIVE]);

  // R6: enabled probe raises the timeout flag
  a_r6_timeout_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.probeRd && ctlRegs[IDX_PCFG][BIT_TMO_EN] |=>
      ctlRegs[IDX_PSTAT][BIT_RD_TMO]);

  // R6: probe reads return zero
  a_r6_probe_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.probeRd |=> rspRdata == '0);

  // R7: init-done stays until a direct write to PHY status
  a_r7_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ctlRegs[IDX_PSTAT][BIT_INIT_DONE] &&
    !(ctlWr && stb.idx == WORD_IDX_W'(IDX_PSTAT)) |=>
      ctlRegs[IDX_PSTAT][BIT_INIT_DONE]);

  // R9: out-of-range reads return zero
  a_r9_oor_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdReq && !stb.inRange |=> rspRdata == '0);

endmodule

// File: rtl/dram_boot_regs.sv
module dram_boot_regs
  import dram_boot_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_CTL = 72,
  parameter int NUM_PHY = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic                  reqSelCom,
  input  logic                  reqSelCtl,
  input  logic                  reqSelPhy,
  input  logic                  reqSelProbe,
  input  logic [WIN_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspRdata,
  output logic [4:0]            geoRowBits,
  output logic [1:0]            geoBankBits,
  output logic [4:0]            geoColBits,
  output logic                  geoUpdate
);

  strobe_t stb;

  assign reqReady = 1'b1;

  dram_boot_ctrl #(.NUM_COM(NUM_COM), .NUM_CTL(NUM_CTL), .NUM_PHY(NUM_PHY)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSelCom(reqSelCom), .reqSelCtl(reqSelCtl), .reqSelPhy(reqSelPhy),
    .reqSelProbe(reqSelProbe), .reqAddr(reqAddr),
    .wBitDual(reqWdata[BIT_DUAL]), .stb(stb), .rspValid(rspValid));

  dram_boot_datapath #(.NUM_COM(NUM_COM), .NUM_CTL(NUM_CTL), .NUM_PHY(NUM_PHY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .rspRdata(rspRdata), .geoRowBits(geoRowBits), .geoBankBits(geoBankBits),
    .geoColBits(geoColBits), .geoUpdate(geoUpdate));

endmodule

// File: tb/sim_dram_boot_regs.sv
`timescale 1ns/1ps
module sim_dram_boot_regs;

  localparam int W_COM = 0, W_CTL = 1, W_PHY = 2, W_PRB = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqSelCom = 1'b0, reqSelCtl = 1'b0, reqSelPhy = 1'b0, reqSelProbe = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, geoUpdate;
  logic [31:0] rspRdata;
  logic [4:0]  geoRowBits, geoColBits;
  logic [1:0]  geoBankBits;

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] rd;
  logic        rv;

  dram_boot_regs #(.NUM_COM(2), .NUM_CTL(72), .NUM_PHY(8)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSelCom(reqSelCom), .reqSelCtl(reqSelCtl),
    .reqSelPhy(reqSelPhy), .reqSelProbe(reqSelProbe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .geoRowBits(geoRowBits), .geoBankBits(geoBankBits),
    .geoColBits(geoColBits), .geoUpdate(geoUpdate));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one access; response and geometry sampled at the following falling edge
  task automatic access(input int win, input logic wr, input logic [11:0] addr,
                        input logic [31:0] data);
    @(negedge clk);
    reqValid    = 1'b1;
    reqWrite    = wr;
    reqAddr     = addr;
    reqWdata    = data;
    reqSelCom   = (win == W_COM);
    reqSelCtl   = (win == W_CTL);
    reqSelPhy   = (win == W_PHY);
    reqSelProbe = (win == W_PRB);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    reqSelCom = 1'b0; reqSelCtl = 1'b0; reqSelPhy = 1'b0; reqSelProbe = 1'b0;
    rd = rspRdata;
    rv = rspValid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset_state();
    check("R8 geo rows after reset", 32'(geoRowBits), 0);
    check("R8 geo banks after reset", 32'(geoBankBits), 0);
    check("R8 geo cols after reset", 32'(geoColBits), 0);
    access(W_CTL, 0, 12'h010, 0); check("R8 phy status after reset", rd, 0);
    access(W_CTL, 0, 12'h018, 0); check("R8 run status after reset", rd, 0);
    access(W_COM, 0, 12'h000, 0); check("R8 control after reset", rd, 0);
    access(W_PHY, 0, 12'h01C, 0); check("R8 phy word after reset", rd, 0);
  endtask

  task automatic t_bus();
    check("R1 ready high", 32'(reqReady), 1);
    access(W_PHY, 1, 12'h01C, 32'hCAFE_0007);
    check("R1 write response valid", 32'(rv), 1);
    check("R1 write response data zero", rd, 0);
    access(W_PHY, 0, 12'h01C, 0);
    check("R1 read response valid", 32'(rv), 1);
    check("R1 phy readback", rd, 32'hCAFE_0007);
    @(negedge clk);
    check("R1 idle no response", 32'(rspValid), 0);
  endtask

  task automatic t_geometry();
    access(W_COM, 1, 12'h000, 32'h0000_0A54);
    check("R2 rows", 32'(geoRowBits), 6);
    check("R2 banks", 32'(geoBankBits), 3);
    check("R2 cols", 32'(geoColBits), 13);
    check("R2 update pulse", 32'(geoUpdate), 1);
    @(negedge clk);
    check("R2 update one cycle", 32'(geoUpdate), 0);
    access(W_COM, 1, 12'h000, 32'h0000_0FF0);
    check("R2 rows max", 32'(geoRowBits), 16);
    check("R2 banks min", 32'(geoBankBits), 2);
    check("R2 cols max", 32'(geoColBits), 18);
    access(W_COM, 0, 12'h000, 0);
    check("R3 control readback", rd, 32'h0000_0FF0);
  endtask

  task automatic t_dual_rank();
    access(W_COM, 1, 12'h000, 32'h0000_0A55);
    check("R4 no pulse", 32'(geoUpdate), 0);
    check("R4 rows held", 32'(geoRowBits), 16);
    check("R4 banks held", 32'(geoBankBits), 2);
    check("R4 cols held", 32'(geoColBits), 18);
    access(W_COM, 0, 12'h000, 0);
    check("R3 dual word stored", rd, 32'h0000_0A55);
  endtask

  task automatic t_init_sticky();
    access(W_CTL, 1, 12'h000, 32'h0000_1234);
    access(W_CTL, 0, 12'h010, 0); check("R5 init done", rd, 32'h1);
    access(W_CTL, 0, 12'h018, 0); check("R5 active", rd, 32'h1);
    access(W_CTL, 0, 12'h000, 0); check("R5 init word stored", rd, 32'h0000_1234);
    access(W_CTL, 1, 12'h014, 32'hFFFF_FFFF);
    access(W_CTL, 1, 12'h01C, 32'hFFFF_FFFF);
    access(W_CTL, 0, 12'h010, 0); check("R7 flag kept", rd, 32'h1);
    access(W_CTL, 1, 12'h010, 32'h0000_0000);
    access(W_CTL, 0, 12'h010, 0); check("R7 direct write clears", rd, 0);
    access(W_CTL, 0, 12'h018, 0); check("R7 other flag kept", rd, 32'h1);
  endtask

  task automatic t_probe();
    access(W_PRB, 0, 12'h040, 0); check("R6 probe zero", rd, 0);
    access(W_CTL, 0, 12'h010, 0); check("R6 no flag when disabled", rd, 0);
    access(W_CTL, 1, 12'h100, 32'h0200_0000);
    access(W_PRB, 1, 12'h000, 32'hFFFF_FFFF);
    access(W_CTL, 0, 12'h010, 0); check("R6 probe write ignored", rd, 0);
    access(W_PRB, 0, 12'h004, 0); check("R6 enabled probe zero", rd, 0);
    access(W_CTL, 0, 12'h010, 0); check("R6 timeout flag", rd, 32'h0000_2000);
    access(W_CTL, 1, 12'h100, 32'h0);
    access(W_PRB, 0, 12'h008, 0);
    access(W_CTL, 0, 12'h010, 0); check("R7 timeout sticky", rd, 32'h0000_2000);
  endtask

  task automatic t_range();
    access(W_PHY, 1, 12'h000, 32'h1111_1111);
    access(W_PHY, 1, 12'h020, 32'h2222_2222);
    access(W_PHY, 0, 12'h020, 0); check("R9 phy oor read zero", rd, 0);
    access(W_PHY, 0, 12'h000, 0); check("R9 phy no alias", rd, 32'h1111_1111);
    access(W_COM, 1, 12'h008, 32'h0000_0001);
    access(W_COM, 0, 12'h008, 0); check("R9 com oor read zero", rd, 0);
    access(W_COM, 0, 12'h000, 0); check("R9 com no alias", rd, 32'h0000_0A55);
    check("R9 geo untouched", 32'(geoRowBits), 16);
    access(W_CTL, 0, 12'h120, 0); check("R9 ctl oor read zero", rd, 0);
  endtask

  task automatic t_reset_again();
    do_reset();
    check("R8 geo rows cleared", 32'(geoRowBits), 0);
    access(W_CTL, 0, 12'h010, 0); check("R8 phy status cleared", rd, 0);
    access(W_CTL, 0, 12'h000, 0); check("R8 init word cleared", rd, 0);
    access(W_COM, 0, 12'h000, 0); check("R8 control cleared", rd, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_bus();
    t_geometry();
    t_dual_rank();
    t_init_sticky();
    t_probe();
    t_range();
    t_reset_again();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule